// File: doc/BRIEF.md
# Banked and Linear Framebuffer Address Mapper

This block sits between a host memory bus and a byte-wide video memory. Each host access arrives with a physical address and a read or write strobe. The block turns that address into a byte offset into video memory, or rejects the access.

An address at or above a programmable linear base is a direct linear access: the offset is the distance from that base. A lower address that is still below the end of the 64 KB legacy graphics window at 0xA0000 is a banked access. For a banked access, a bank number is scaled by a selectable granule of 32 KB or 64 KB, and the low 16 address bits are added to it.

Some accesses are rejected. These are addresses between the window end and the linear base, and any offset that lands at or past the installed memory size. A rejected read returns zero and a rejected write never reaches memory. Writes go to memory in the cycle of the strobe. Read data comes back one cycle after the strobe, together with a valid pulse.

Top module: `fb_addr_map`

## Requirements
- R1: While rst_ni is low, and in the first cycle after reset with no read, rvalid_o and rdata_o are 0.
- R2: An address at or above lfb_base_i maps to offset = address − lfb_base_i.
- R3: With gran32_i = 0, an address below lfb_base_i and below 0xB0000 maps to offset = bank_i × 65536 + (address AND 0xFFFF).
- R4: With gran32_i = 1, such an address maps to offset = bank_i × 32768 + (address AND 0xFFFF). A large low part may therefore spill into the following granule.
- R5: An address at or above 0xB0000 but below lfb_base_i is rejected. A read returns 0 and a write leaves mem_we_o low.
- R6: An access whose offset is at or beyond MEM_BYTES is rejected. A read returns 0 and a write leaves mem_we_o low.
- R7: A read strobe in cycle n gives rvalid_o = 1 and the read data in cycle n+1. rvalid_o is 0 in every cycle that does not follow a read strobe.
- R8: An accepted write raises mem_we_o in the same cycle as wr_i. In that cycle mem_addr_o holds the low MEM_AW bits of the offset and mem_wdata_o equals wdata_i.
- R9: The linear comparison takes priority. When lfb_base_i lies inside the banked window, addresses at or above it use the linear mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| haddr_i | input | AW | Host physical byte address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Host write byte |
| lfb_base_i | input | AW | Linear framebuffer base address |
| bank_i | input | BANK_W | Current bank number |
| gran32_i | input | 1 | 1 selects 32 KB granule, 0 selects 64 KB |
| mem_addr_o | output | MEM_AW | Video memory byte address |
| mem_we_o | output | 1 | Video memory write enable |
| mem_wdata_o | output | 8 | Video memory write byte |
| mem_rdata_i | input | 8 | Video memory read byte (combinational with mem_addr_o) |
| rdata_o | output | 8 | Read data returned to host |
| rvalid_o | output | 1 | rdata_o valid |

## Verification
The bench sweeps bank numbers and in-window low addresses for both granules. Comparing 32 KB against 64 KB results separates the scale factor and exposes the spill of a high low part into the next granule. It also sweeps linear addresses on both sides of the memory-size limit, and banked cases just under and just over that limit, which isolate the out-of-memory guard. Addresses in the gap above the window, and a linear base placed inside the window, tell apart the three-way region ordering. Each pattern is run as both a write, checked in the strobe cycle, and a read, checked one cycle later against an arithmetic memory model.

// File: rtl/fb_map_pkg.sv
package fb_map_pkg;
  typedef enum logic [1:0] {
    REG_LIN  = 2'd0,
    REG_BANK = 2'd1,
    REG_NONE = 2'd2
  } region_e;
endpackage

// File: rtl/fb_region_dec.sv
module fb_region_dec
  import fb_map_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned WIN_BASE = 32'h000A_0000
) (
  input  logic [AW-1:0] haddr_i,
  input  logic [AW-1:0] lfb_base_i,
  output region_e       region_o
);
  localparam logic [AW-1:0] WIN_LIM = AW'(WIN_BASE + 32'h0001_0000);

  // linear compare first: a base inside the window wins
  always_comb begin
    if (haddr_i >= lfb_base_i)   region_o = REG_LIN;
    else if (haddr_i < WIN_LIM)  region_o = REG_BANK;
    else                         region_o = REG_NONE;
  end
endmodule

// File: rtl/fb_bank_calc.sv
module fb_bank_calc #(
  parameter int unsigned AW     = 32,
  parameter int unsigned BANK_W = 9
) (
  input  logic [15:0]       low_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              gran32_i,
  output logic [AW-1:0]     off_o
);
  localparam int unsigned BB_W = BANK_W + 16;

  logic [BB_W-1:0] bank_base;

  always_comb begin
    if (gran32_i) bank_base = {1'b0, bank_i, 15'd0};
    else          bank_base = {bank_i, 16'd0};
    off_o = AW'(bank_base) + AW'(low_i);
  end
endmodule

// File: rtl/fb_rd_stage.sv
module fb_rd_stage (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_i,
  input  logic       hit_i,
  input  logic [7:0] mem_rdata_i,
  output logic [7:0] rdata_o,
  output logic       rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= 8'd0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= hit_i ? mem_rdata_i : 8'd0;
    end
  end

  // R7
  rd_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
  // R7
  no_spur_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);
  // R5
  rej_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !hit_i) |=> (rdata_o == 8'd0));
endmodule

// File: rtl/fb_addr_map.sv
module fb_addr_map
  import fb_map_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned BANK_W    = 9,
  parameter int unsigned MEM_BYTES = 262144,
  parameter int unsigned WIN_BASE  = 32'h000A_0000,
  localparam int unsigned MEM_AW   = $clog2(MEM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     haddr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic [AW-1:0]     lfb_base_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              gran32_i,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o
);
  localparam logic [AW-1:0] MEM_LIM = AW'(MEM_BYTES);
  localparam logic [AW-1:0] WIN_LIM = AW'(WIN_BASE + 32'h0001_0000);

  region_e       region;
  logic [AW-1:0] bank_off;
  logic [AW-1:0] off;
  logic          hit;

  fb_region_dec #(.AW(AW), .WIN_BASE(WIN_BASE)) u_dec (
    .haddr_i    (haddr_i),
    .lfb_base_i (lfb_base_i),
    .region_o   (region)
  );

  fb_bank_calc #(.AW(AW), .BANK_W(BANK_W)) u_bank (
    .low_i    (haddr_i[15:0]),
    .bank_i   (bank_i),
    .gran32_i (gran32_i),
    .off_o    (bank_off)
  );

  always_comb begin
    off = (region == REG_LIN) ? (haddr_i - lfb_base_i) : bank_off;
    hit = (region != REG_NONE) && (off < MEM_LIM);
  end

  assign mem_addr_o  = off[MEM_AW-1:0];
  assign mem_we_o    = wr_i && hit;
  assign mem_wdata_o = wdata_i;

  fb_rd_stage u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (rd_i),
    .hit_i       (hit),
    .mem_rdata_i (mem_rdata_i),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o)
  );

  // R8
  we_needs_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> wr_i);
  // R6
  we_in_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (off < MEM_LIM));
  // R5
  we_not_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ((haddr_i >= lfb_base_i) || (haddr_i < WIN_LIM)));
endmodule

// File: tb/fb_addr_map_tb.sv
`timescale 1ns/1ps
module fb_addr_map_tb;
  localparam int MEMB = 262144;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] haddr = '0, lfb_base = 32'hE000_0000;
  logic        rd = 1'b0, wr = 1'b0, g32 = 1'b0;
  logic [7:0]  wdata = '0;
  logic [8:0]  bank = '0;
  logic [17:0] mem_addr;
  logic        mem_we, rvalid;
  logic [7:0]  mem_wdata, mem_rdata, rdata;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  assign mem_rdata = mem_addr[7:0] ^ mem_addr[15:8] ^ {6'd0, mem_addr[17:16]};

  fb_addr_map u_dut (
    .clk_i(clk), .rst_ni(rst_n), .haddr_i(haddr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .lfb_base_i(lfb_base), .bank_i(bank), .gran32_i(g32),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  function automatic logic [7:0] model(longint o);
    logic [17:0] a = o[17:0];
    return a[7:0] ^ a[15:8] ^ {6'd0, a[17:16]};
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_map(input longint a, output bit hit, output longint off);
    if (a >= longint'(lfb_base)) begin
      off = a - longint'(lfb_base); hit = 1;
    end else if (a < 64'hB0000) begin
      off = longint'(bank) * (g32 ? 32768 : 65536) + (a & 64'hFFFF); hit = 1;
    end else begin
      off = 0; hit = 0;
    end
    if (off >= MEMB) hit = 0;
  endtask

  task automatic access(string tag, longint a);
    bit hit; longint off;
    expect_map(a, hit, off);
    @(negedge clk);
    haddr = a[31:0]; wr = 1'b1; wdata = a[7:0] ^ 8'h5A;
    #1;
    chk({tag, " we"}, mem_we, hit);
    if (hit) begin
      chk({tag, " R8 addr"}, mem_addr, off[17:0]);
      chk({tag, " R8 wdata"}, mem_wdata, a[7:0] ^ 8'h5A);
    end
    @(negedge clk);
    wr = 1'b0; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk({tag, " R7 rvalid"}, rvalid, 1);
    chk({tag, " rdata"}, rdata, hit ? model(off) : 0);
    @(negedge clk);
    chk({tag, " R7 idle"}, rvalid, 0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #7;
    chk("R1 rvalid in reset", rvalid, 0);
    chk("R1 rdata in reset", rdata, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rvalid after reset", rvalid, 0);
    chk("R1 rdata after reset", rdata, 0);

    for (int g = 0; g < 2; g++) begin
      g32 = g[0];
      for (int b = 0; b < 10; b++) begin
        bank = b[8:0];
        for (int k = 0; k < 5; k++) begin
          longint lo = (k == 4) ? 64'hFFFF : longint'(k) * 64'h3A17;
          access(g32 ? "R4 bank32" : "R3 bank64", 64'hA0000 + lo);
        end
      end
    end
    // R6 banked edge cases
    g32 = 1'b1; bank = 9'd7; access("R6 bank32 spill", 64'hA7FFF);
    access("R6 bank32 spill over", 64'hA8000);
    g32 = 1'b0; bank = 9'd3; access("R6 bank64 last", 64'hAFFFF);
    bank = 9'd4; access("R6 bank64 over", 64'hA0000);
    bank = 9'd300; access("R6 bank64 far", 64'hA1234);
    // R2 linear sweep
    bank = 9'd1;
    for (int i = 0; i < 24; i++)
      access("R2 linear", 64'hE000_0000 + longint'(i) * 64'h2D1B);
    access("R2 linear last", 64'hE003_FFFF);
    access("R6 linear over", 64'hE004_0000);
    access("R6 linear far", 64'hFFFF_FFFF);
    // R5 gap region
    access("R5 gap low", 64'hB0000);
    access("R5 gap mid", 64'h0123_4567);
    access("R5 gap high", 64'hDFFF_FFFF);
    // R9 base inside window
    lfb_base = 32'h000A_8000; bank = 9'd2; g32 = 1'b0;
    access("R9 below base", 64'hA7FFF);
    access("R9 at base", 64'hA8000);
    access("R9 above base", 64'hAC321);
    access("R9 old gap now linear", 64'hB0000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule